// File: doc/BRIEF.md
# Program write latch for aligned eight-word blocks

This block gathers up to eight program words that belong to one aligned block of program flash and then hands the whole block to the flash sequencer as a single write. The sequencer has already checked the unlock sequence, so each strobe it presents here is legitimate. Every strobe comes with an address, a 14-bit word and a load-only flag.

With the flag raised, the word is only parked in the latch that the low three address bits select. With the flag lowered, the word is parked the same way and the full set of eight latches is then offered to the sequencer as one commit. Latches that received nothing go out as all ones, which leaves those flash words unprogrammed.

The first accepted word fixes which block is held. A later word for a different block is refused with a one-cycle boundary-error pulse. Strobes that arrive while a commit is waiting for its acknowledge are refused with a one-cycle busy-error pulse. Parking a word never stalls. Only the commit waits, and it holds until the sequencer acknowledges it, at which point every latch returns to all ones.

Top module: `pgm_write_latch`

## Requirements
- R1: A strobe with `ld_hold`=1 that is accepted writes `ld_data` into slot `ld_addr[2:0]`, and `cm_req` stays 0 after it.
- R2: A strobe with `ld_hold`=0 that is accepted writes its own word into slot `ld_addr[2:0]`, and `cm_req` is 1 from the next cycle on. Slot i is `cm_data[i*14 +: 14]`.
- R3: Every slot not written since reset or since the last acknowledged commit reads as 14'h3FFF on `cm_data`.
- R4: While `cm_req` is 1, `cm_base` equals the held block's address with bits [2:0] forced to zero.
- R5: When at least one slot holds a word, a strobe whose `ld_addr[14:3]` differs from the held block stores nothing, raises no commit, and pulses `bnd_err` for one cycle.
- R6: A strobe that arrives while `cm_req` is 1 stores nothing and pulses `busy_err` for one cycle.
- R7: `cm_ack` together with `cm_req` drops `cm_req` on the next cycle and returns all eight slots to 14'h3FFF. `cm_ack` without `cm_req` changes nothing.
- R8: After reset, `cm_req`, `bnd_err` and `busy_err` are 0 and every slot reads 14'h3FFF.
- R9: While `cm_req` is 1 and no acknowledge arrives, `cm_req`, `cm_data` and `cm_base` hold their values.
- R10: A second accepted word for the same slot replaces the first.
- R11: When no slot holds a word, a strobe for any block is accepted and makes that block the held one. This includes a commit strobe, which then sends a single word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Write strobe from the sequencer, already validated |
| ld_hold | input | 1 | 1: park the word only; 0: park the word and commit the block |
| ld_addr | input | 15 | Word address of the strobe |
| ld_data | input | 14 | Program word to park |
| cm_req | output | 1 | Commit pending toward the array |
| cm_ack | input | 1 | Sequencer has taken the commit |
| cm_base | output | 15 | Base address of the committed block, low three bits zero |
| cm_data | output | 112 | Eight slots, slot i at bits [i*14 +: 14] |
| bnd_err | output | 1 | One-cycle pulse: strobe dropped for crossing the block |
| busy_err | output | 1 | One-cycle pulse: strobe dropped while a commit was pending |

## Verification
The properties assume that the sequencer raises `cm_ack` only in response to `cm_req`, and that every input is stable and known at each rising edge once reset is released. The stimulus changes inputs only on falling edges. It raises the acknowledge only as a separate step with no strobe in the same cycle, apart from one deliberate case that checks an acknowledge arriving with no request pending. Strobes that collide with a pending commit or point at a foreign block are sent on purpose, so that both refusal paths are exercised.

// File: rtl/wl_pkg.sv
package wl_pkg;

    // What happens to one incoming strobe
    typedef enum logic [1:0] {
        WL_IDLE     = 2'd0,
        WL_STORE    = 2'd1,
        WL_REJ_BND  = 2'd2,
        WL_REJ_BUSY = 2'd3
    } wl_outcome_e;

endpackage

// File: rtl/wl_decide.sv
module wl_decide
    import wl_pkg::*;
(
    input  logic        strobe,
    input  logic        hold_only,
    input  logic        pending,
    input  logic        held_any,
    input  logic        same_block,
    output wl_outcome_e outcome,
    output logic        fire
);

    always_comb begin
        if (!strobe) begin
            outcome = WL_IDLE;
        end else if (pending) begin
            outcome = WL_REJ_BUSY;
        end else if (held_any && !same_block) begin
            outcome = WL_REJ_BND;
        end else begin
            outcome = WL_STORE;
        end
        fire = (outcome == WL_STORE) && !hold_only;
    end

endmodule

// File: rtl/wl_slot_bank.sv
module wl_slot_bank #(
    parameter int DATA_W = 14,
    parameter int SLOTS  = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    clr,
    output logic [SLOTS*DATA_W-1:0] rd_flat,
    output logic [SLOTS-1:0]        valid_mask
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] word_d, word_q;
        logic              vld_d, vld_q;
        logic              hit;

        always_comb begin
            hit    = wr_en && (wr_idx == IDX_W'(g));
            word_d = word_q;
            vld_d  = vld_q;
            if (clr) begin
                word_d = '1;
                vld_d  = 1'b0;
            end else if (hit) begin
                word_d = wr_data;
                vld_d  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
                vld_q  <= 1'b0;
            end else begin
                word_q <= word_d;
                vld_q  <= vld_d;
            end
        end

        assign rd_flat[g*DATA_W +: DATA_W] = word_q;
        assign valid_mask[g]               = vld_q;
    end

endmodule

// File: rtl/pgm_write_latch.sv
module pgm_write_latch
    import wl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 14,
    parameter int SLOTS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_valid,
    input  logic                    ld_hold,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [DATA_W-1:0]       ld_data,
    output logic                    cm_req,
    input  logic                    cm_ack,
    output logic [ADDR_W-1:0]       cm_base,
    output logic [SLOTS*DATA_W-1:0] cm_data,
    output logic                    bnd_err,
    output logic                    busy_err
);

    localparam int IDX_W = $clog2(SLOTS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic             pend;
        logic [TAG_W-1:0] tag;
        logic             bnd;
        logic             busy;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    wl_outcome_e outcome;
    logic        fire;
    logic        held_any;
    logic        same_block;
    logic        slot_we;
    logic        slot_clr;
    logic [SLOTS-1:0] mask;

    assign same_block = (ld_addr[ADDR_W-1:IDX_W] == ctl_q.tag);
    assign held_any   = |mask;

    wl_decide u_decide (
        .strobe     (ld_valid),
        .hold_only  (ld_hold),
        .pending    (ctl_q.pend),
        .held_any   (held_any),
        .same_block (same_block),
        .outcome    (outcome),
        .fire       (fire)
    );

    always_comb begin
        ctl_d    = ctl_q;
        slot_we  = (outcome == WL_STORE);
        slot_clr = ctl_q.pend && cm_ack;
        ctl_d.bnd  = (outcome == WL_REJ_BND);
        ctl_d.busy = (outcome == WL_REJ_BUSY);
        if (ctl_q.pend) begin
            ctl_d.pend = !cm_ack;
        end else begin
            ctl_d.pend = fire;
        end
        if (slot_we && !held_any) begin
            ctl_d.tag = ld_addr[ADDR_W-1:IDX_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    wl_slot_bank #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (slot_we),
        .wr_idx     (ld_addr[IDX_W-1:0]),
        .wr_data    (ld_data),
        .clr        (slot_clr),
        .rd_flat    (cm_data),
        .valid_mask (mask)
    );

    assign cm_req   = ctl_q.pend;
    assign cm_base  = {ctl_q.tag, {IDX_W{1'b0}}};
    assign bnd_err  = ctl_q.bnd;
    assign busy_err = ctl_q.busy;

endmodule

// File: rtl/wl_latch_chk.sv
module wl_latch_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 14,
    parameter int SLOTS  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ld_valid,
    input logic                    ld_hold,
    input logic                    cm_req,
    input logic                    cm_ack,
    input logic [ADDR_W-1:0]       cm_base,
    input logic [SLOTS*DATA_W-1:0] cm_data,
    input logic                    bnd_err,
    input logic                    busy_err
);

    localparam int IDX_W = $clog2(SLOTS);

    // R1
    hold_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_hold && !cm_req) |=> !cm_req);

    // R4
    base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_req |-> (cm_base[IDX_W-1:0] == '0));

    // R6
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && cm_req) |=> busy_err);

    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_req && cm_ack) |=> (!cm_req && (cm_data == '1)));

    // R9
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_req && !cm_ack) |=> (cm_req && $stable(cm_data) && $stable(cm_base)));

    // R5
    err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bnd_err, busy_err}));

endmodule

bind pgm_write_latch wl_latch_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SLOTS  (SLOTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_hold  (ld_hold),
    .cm_req   (cm_req),
    .cm_ack   (cm_ack),
    .cm_base  (cm_base),
    .cm_data  (cm_data),
    .bnd_err  (bnd_err),
    .busy_err (busy_err)
);

// File: tb/pgm_write_latch_tb.sv
module pgm_write_latch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    // {op[1:0], addr[14:0], data[13:0], exp_req, exp_bnd, exp_busy}
    // op: 0 idle, 1 park only, 2 park and commit, 3 acknowledge
    localparam logic [33:0] VEC [NV] = '{
        {2'd1, 15'h0122, 14'h01AB, 3'b000},  // R1 R11 first word fixes block
        {2'd1, 15'h0125, 14'h0333, 3'b000},  // R1
        {2'd1, 15'h0208, 14'h0777, 3'b010},  // R5 foreign block
        {2'd1, 15'h0122, 14'h0044, 3'b000},  // R10 overwrite slot 2
        {2'd2, 15'h0127, 14'h3FFE, 3'b100},  // R2 R3 R4 commit
        {2'd1, 15'h0121, 14'h0101, 3'b101},  // R6 busy
        {2'd0, 15'h0000, 14'h0000, 3'b100},  // R9 still pending
        {2'd3, 15'h0000, 14'h0000, 3'b000},  // R7 release
        {2'd2, 15'h7FF8, 14'h0001, 3'b100},  // R11 single-word commit
        {2'd3, 15'h0000, 14'h0000, 3'b000},  // R7
        {2'd1, 15'h0013, 14'h2222, 3'b000},  // R1
        {2'd2, 15'h0050, 14'h0F0F, 3'b010},  // R5 foreign commit dropped
        {2'd2, 15'h0010, 14'h1111, 3'b100},  // R2 R4
        {2'd3, 15'h0000, 14'h0000, 3'b000}   // R7
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic         ld_hold = 1'b0;
    logic [14:0]  ld_addr = '0;
    logic [13:0]  ld_data = '0;
    logic         cm_ack = 1'b0;
    logic         cm_req;
    logic [14:0]  cm_base;
    logic [111:0] cm_data;
    logic         bnd_err;
    logic         busy_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [13:0] exp_mem [8];
    logic [14:0] exp_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgm_write_latch u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_hold  (ld_hold),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .cm_req   (cm_req),
        .cm_ack   (cm_ack),
        .cm_base  (cm_base),
        .cm_data  (cm_data),
        .bnd_err  (bnd_err),
        .busy_err (busy_err)
    );

    function automatic logic [111:0] pack_mem();
        logic [111:0] v;
        for (int i = 0; i < 8; i++) v[i*14 +: 14] = exp_mem[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [111:0] act,
                       input logic [111:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic step(input logic [1:0] op, input logic [14:0] a, input logic [13:0] d);
        ld_valid = (op == 2'd1) || (op == 2'd2);
        ld_hold  = (op == 2'd1);
        ld_addr  = a;
        ld_data  = d;
        cm_ack   = (op == 2'd3);
        @(negedge clk);
        ld_valid = 1'b0;
        cm_ack   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) exp_mem[i] = 14'h3FFF;
        exp_base = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(cm_req == 1'b0, "R8 req", 112'(cm_req), 112'(0));
        chk({bnd_err, busy_err} == 2'b00, "R8 errs", 112'({bnd_err, busy_err}), 112'(0));
        chk(cm_data == '1, "R8 R3 data", cm_data, '1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic [1:0]  op;
            logic [14:0] a;
            logic [13:0] d;
            logic        er, eb, ey;
            op = VEC[k][33:32];
            a  = VEC[k][31:17];
            d  = VEC[k][16:3];
            er = VEC[k][2];
            eb = VEC[k][1];
            ey = VEC[k][0];
            step(op, a, d);
            if ((op == 2'd1 || op == 2'd2) && !eb && !ey) begin
                exp_mem[a[2:0]] = d;
                if (op == 2'd2) exp_base = {a[14:3], 3'b000};
            end
            if (op == 2'd3) begin
                for (int i = 0; i < 8; i++) exp_mem[i] = 14'h3FFF;
            end
            chk(cm_req == er, $sformatf("R2 R7 req v%0d", k), 112'(cm_req), 112'(er));
            chk(bnd_err == eb, $sformatf("R5 bnd v%0d", k), 112'(bnd_err), 112'(eb));
            chk(busy_err == ey, $sformatf("R6 busy v%0d", k), 112'(busy_err), 112'(ey));
            chk(cm_data == pack_mem(), $sformatf("R1 R3 R10 data v%0d", k), cm_data, pack_mem());
            if (er) chk(cm_base == exp_base, $sformatf("R4 base v%0d", k),
                        112'(cm_base), 112'(exp_base));
        end

        // R7 acknowledge with nothing pending changes nothing
        step(2'd1, 15'h0042, 14'h0555);
        step(2'd3, 15'h0000, 14'h0000);
        chk(cm_req == 1'b0, "R7 stray ack req", 112'(cm_req), 112'(0));
        chk(cm_data[2*14 +: 14] == 14'h0555, "R7 stray ack slot2",
            112'(cm_data[2*14 +: 14]), 112'(14'h0555));
        // commit the same block from slot 0, check base and both words
        step(2'd2, 15'h0040, 14'h0AAA);
        chk(cm_req == 1'b1, "R2 req", 112'(cm_req), 112'(1));
        chk(cm_base == 15'h0040, "R4 base", 112'(cm_base), 112'(15'h0040));
        chk(cm_data[13:0] == 14'h0AAA, "R2 slot0", 112'(cm_data[13:0]), 112'(14'h0AAA));
        chk(cm_data[7*14 +: 14] == 14'h3FFF, "R3 slot7",
            112'(cm_data[7*14 +: 14]), 112'(14'h3FFF));
        // R9 several idle cycles keep the commit steady
        step(2'd0, 15'h0000, 14'h0000);
        step(2'd0, 15'h0000, 14'h0000);
        chk(cm_req == 1'b1 && cm_data[2*14 +: 14] == 14'h0555, "R9 hold",
            112'({cm_req, cm_data[2*14 +: 14]}), 112'({1'b1, 14'h0555}));
        step(2'd3, 15'h0000, 14'h0000);
        chk(cm_req == 1'b0 && cm_data == '1, "R7 release", cm_data, '1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule